// File: doc/BRIEF.md
# Segment Base Address Generator

This block maps a virtual address to a linear address through a bank of sixteen segment base registers. A four-bit selector taken from the top of the active address width names the base register. The block multiplies that register's value by sixteen and adds it to the offset. The offset is the address with the selector field and every bit above the active width cleared. The result and the selected register index come out one clock later. A translation stage downstream consumes them.

A mode input sets the active address width, either the full wide width or a narrower one. Because of this, the selector field moves with the mode. Instruction fetches ignore the selector field and always use the code base register. The code base register resets to a fixed start value. All other base registers reset to zero, so an address whose selector field is zero falls on the data base without further setup. A write port loads a base register (move-to-base) and a combinational read port returns one (move-from-base). A write is visible to a read or to an address request in the same cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: With `wide_mode`=1 and `req_fetch`=0, `out_sel` equals `req_addr[31:28]`.
- R2: With `wide_mode`=0 and `req_fetch`=0, `out_sel` equals `req_addr[23:20]`, and bits 31:24 of `req_addr` affect neither `out_sel` nor `out_lin`.
- R3: A data request whose selector field is all zero selects base register 0.
- R4: `out_lin` is (selected base × 16) + offset, truncated to 36 bits. In wide mode the offset is `req_addr[27:0]`; in narrow mode it is `req_addr[19:0]`. All other offset bits are zero.
- R5: When `req_fetch`=1, `out_sel` is 15 in both modes, whatever the upper address bits hold.
- R6: After reset, base register 15 holds `RST_CODE_BASE`, base registers 0 to 14 hold zero, and `out_valid` is 0.
- R7: When `wr_en`=1, base register `wr_idx` takes `wr_data` at the clock edge. When `wr_en`=0, no base register changes.
- R8: `rd_data` returns base register `rd_idx` combinationally. If a write to the same index is present in the same cycle, `rd_data` returns `wr_data`.
- R9: An address request that selects a register being written in the same cycle uses the value being written.
- R10: `out_valid` equals `req_valid` from one cycle earlier. `out_lin` and `out_sel` change only after a cycle with `req_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: 32-bit address width, 0: 24-bit address width |
| req_valid | input | 1 | Address request present |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Virtual address |
| wr_en | input | 1 | Move-to-base write enable |
| wr_idx | input | 4 | Base register to write |
| wr_data | input | 32 | Base value to write |
| rd_idx | input | 4 | Base register to read |
| rd_data | output | 32 | Move-from-base read data |
| out_valid | output | 1 | Linear address valid |
| out_lin | output | 36 | Linear address |
| out_sel | output | 4 | Base register index used |

## Verification
The bench builds the block with its default widths: a 32-bit wide mode, a 24-bit narrow mode and 32-bit base registers. It overrides the code base start value with a non-trivial pattern, so a reset that loads the wrong register or the wrong value shows up. Scaling a 32-bit base by sixteen gives a 36-bit sum. Bases with high bits set therefore expose a carry that a 32-bit adder would drop. The two widths make the selector field move between bit 28 and bit 20, which brings the masking of bits above the narrow width within reach.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    localparam int SEL_W    = 4;
    localparam int NUM_BASE = 1 << SEL_W;
    localparam int GRAN_SH  = 4;
    localparam logic [SEL_W-1:0] DATA_SEL = 4'd0;
    localparam logic [SEL_W-1:0] CODE_SEL = 4'd15;

    typedef enum logic {
        AW_NARROW = 1'b0,
        AW_WIDE   = 1'b1
    } aw_mode_e;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 24
) (
    input  aw_mode_e           mode,
    input  logic               fetch,
    input  logic [ADDR_W-1:0]  addr,
    output logic [SEL_W-1:0]   sel,
    output logic [ADDR_W-1:0]  offset
);
    localparam int WIDE_KEEP = ADDR_W - SEL_W;
    localparam int NAR_KEEP  = NARROW_W - SEL_W;

    logic [SEL_W-1:0] field;

    always_comb begin
        offset = '0;
        if (mode == AW_WIDE) begin
            field = addr[ADDR_W-1 -: SEL_W];
            offset[WIDE_KEEP-1:0] = addr[WIDE_KEEP-1:0];
        end else begin
            field = addr[NARROW_W-1 -: SEL_W];
            offset[NAR_KEEP-1:0] = addr[NAR_KEEP-1:0];
        end
        sel = fetch ? CODE_SEL : field;
    end

endmodule

// File: rtl/seg_base_file.sv
module seg_base_file
    import seg_agu_pkg::*;
#(
    parameter int                BASE_W        = 32,
    parameter logic [BASE_W-1:0] RST_CODE_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  ag_idx,
    output logic [BASE_W-1:0] ag_base
);
    logic [BASE_W-1:0]   regs [NUM_BASE];
    logic [NUM_BASE-1:0] we_vec;

    genvar g;
    generate
        for (g = 0; g < NUM_BASE; g++) begin : g_we
            assign we_vec[g] = wr_en && (wr_idx == SEL_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BASE; i++) begin
            if (rst)
                regs[i] <= (SEL_W'(i) == CODE_SEL) ? RST_CODE_BASE : '0;
            else if (we_vec[i])
                regs[i] <= wr_data;
        end
    end

    assign rd_data = (wr_en && wr_idx == rd_idx) ? wr_data : regs[rd_idx];
    assign ag_base = (wr_en && wr_idx == ag_idx) ? wr_data : regs[ag_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R7

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs[$past(rd_idx)] == $past(rd_data)); // R7

    AST_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_idx == wr_idx) |-> rd_data == wr_data); // R8

    AST_REQ_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ag_idx == wr_idx) |-> ag_base == wr_data); // R9

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_agu_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                NARROW_W      = 24,
    parameter int                BASE_W        = 32,
    parameter logic [BASE_W-1:0] RST_CODE_BASE = 32'h0000_0100,
    localparam int               LIN_W         = BASE_W + GRAN_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              req_valid,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_data,
    output logic              out_valid,
    output logic [LIN_W-1:0]  out_lin,
    output logic [SEL_W-1:0]  out_sel
);
    typedef struct packed {
        logic [LIN_W-1:0] lin;
        logic [SEL_W-1:0] sel;
    } lin_res_t;

    aw_mode_e          mode;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] offset;
    logic [BASE_W-1:0] base;
    lin_res_t          nxt, res_q;

    assign mode = aw_mode_e'(wide_mode);

    seg_sel_decode #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_dec (
        .mode   (mode),
        .fetch  (req_fetch),
        .addr   (req_addr),
        .sel    (sel),
        .offset (offset)
    );

    seg_base_file #(
        .BASE_W        (BASE_W),
        .RST_CODE_BASE (RST_CODE_BASE)
    ) u_bases (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ag_idx  (sel),
        .ag_base (base)
    );

    always_comb begin
        nxt.lin = {base, {GRAN_SH{1'b0}}} + LIN_W'(offset);
        nxt.sel = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid)
                res_q <= nxt;
        end
    end

    assign out_lin = res_q.lin;
    assign out_sel = res_q.sel;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R10

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(out_lin) && $stable(out_sel))); // R10

    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fetch) |=> out_sel == CODE_SEL); // R5

    AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_fetch && wide_mode && req_addr[ADDR_W-1 -: SEL_W] == '0)
        |=> out_sel == DATA_SEL); // R3

endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;

    localparam logic [31:0] RST_CB = 32'h0ABC_DE01;

    logic        clk = 1'b0;
    logic        rst;
    logic        wide_mode, req_valid, req_fetch, wr_en;
    logic [31:0] req_addr, wr_data, rd_data;
    logic [3:0]  wr_idx, rd_idx, out_sel;
    logic        out_valid;
    logic [35:0] out_lin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] bm [16];

    always #2 clk = ~clk;

    seg_addr_gen #(.RST_CODE_BASE(RST_CB)) u0 (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .req_valid(req_valid),
        .req_fetch(req_fetch), .req_addr(req_addr), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .out_valid(out_valid), .out_lin(out_lin), .out_sel(out_sel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic w, input logic f, input logic [31:0] a);
        if (f) return 4'd15;
        return w ? a[31:28] : a[23:20];
    endfunction

    function automatic logic [35:0] exp_lin(input logic w, input logic f, input logic [31:0] a);
        logic [35:0] off;
        off = w ? {8'd0, a[27:0]} : {16'd0, a[19:0]};
        return {bm[exp_sel(w, f, a)], 4'd0} + off;
    endfunction

    task automatic do_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_data = d; rd_idx = idx;
        #1 check("R8 same-cycle read bypass", rd_data, d);
        @(negedge clk);
        wr_en = 0; wr_data = ~d; bm[idx] = d;
        #1 check("R7 written base read back", rd_data, d);
    endtask

    task automatic do_req(input string tag, input logic w, input logic f, input logic [31:0] a);
        logic [35:0] el;
        logic [3:0]  es;
        @(negedge clk);
        wide_mode = w; req_fetch = f; req_addr = a; req_valid = 1;
        el = exp_lin(w, f, a); es = exp_sel(w, f, a);
        @(posedge clk); #1;
        check({tag, " valid"}, out_valid, 1);
        check({tag, " sel"}, out_sel, es);
        check({tag, " lin"}, out_lin, el);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset;
        rst = 1; wide_mode = 1; req_valid = 0; req_fetch = 0; req_addr = 0;
        wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 15;
        for (int i = 0; i < 16; i++) bm[i] = (i == 15) ? RST_CB : 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 check("R6 out_valid after reset", out_valid, 0);
        check("R6 code base reset value", rd_data, RST_CB);
        rd_idx = 9;
        #1 check("R6 other base zero", rd_data, 0);
    endtask

    task automatic t_regs;
        for (int i = 0; i < 16; i++)
            do_write(4'(i), 32'h1111_0000 * (i + 1) + 32'h35 * i);
        do_write(4'd3, 32'h1234_5678);
        do_write(4'd0, 32'h0000_2000);
        do_write(4'd9, 32'hF000_0007);
        // R7: no write while wr_en is low
        @(negedge clk);
        wr_en = 0; wr_idx = 3; wr_data = 32'hDEAD_BEEF; rd_idx = 3;
        @(negedge clk);
        #1 check("R7 no write when disabled", rd_data, bm[3]);
    endtask

    task automatic t_wide;
        do_req("R1 R4 wide sel3", 1, 0, 32'h3ABC_DEF1);
        do_req("R1 R4 wide sel9 carry", 1, 0, 32'h9FFF_FFFF);
        do_req("R1 R4 wide sel15", 1, 0, 32'hF000_0010);
        do_req("R3 wide zero selector", 1, 0, 32'h0123_4567);
    endtask

    task automatic t_narrow;
        do_req("R2 R4 narrow sel3 junk high", 0, 0, 32'hA53A_BCDE);
        do_req("R2 R4 narrow sel9", 0, 0, 32'h0097_6543);
        do_req("R3 narrow zero selector", 0, 0, 32'hFF0F_FFFF);
    endtask

    task automatic t_fetch;
        do_req("R5 fetch wide", 1, 1, 32'h3000_0040);
        do_req("R5 fetch narrow", 0, 1, 32'h0090_1234);
    endtask

    task automatic t_req_bypass;
        logic [35:0] el;
        @(negedge clk);
        wr_en = 1; wr_idx = 5; wr_data = 32'h0765_4321;
        wide_mode = 1; req_fetch = 0; req_addr = 32'h5000_0ABC; req_valid = 1;
        bm[5] = 32'h0765_4321;
        el = exp_lin(1, 0, 32'h5000_0ABC);
        @(posedge clk); #1;
        check("R9 request uses same-cycle write", out_lin, el);
        @(negedge clk);
        wr_en = 0; req_valid = 0;
    endtask

    task automatic t_latency;
        logic [35:0] held;
        do_req("R10 latency", 1, 0, 32'h3000_0001);
        held = out_lin;
        req_addr = 32'h9111_1111;
        @(posedge clk); #1;
        check("R10 valid drops", out_valid, 0);
        check("R10 lin holds", out_lin, held);
        check("R10 sel holds", out_sel, 3);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_wide();
        t_narrow();
        t_fetch();
        t_req_bypass();
        t_latency();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule